// File: doc/BRIEF.md
# Periodic Oscillator Drift Compensator

This block turns a stream of 32.768 kHz tick enables into second boundaries and corrects for crystal frequency error. A second normally spans a fixed nominal number of ticks. Once per compensation interval, the first second of the interval is lengthened or shortened by a signed number of ticks. The interval lasts from 1 to 256 seconds. A downstream seconds counter advances on the one-cycle `sec_pulse` output.

Software writes two settings: an interval code and a signed tick adjustment. Each write lands in a pending register that reads back at once. The running interval keeps the values it started with. The pending values move into use only when the current interval ends, so a new setting never splits an interval. Two readback outputs show the live state: the seconds left in the current interval, and the adjustment applied to the second now being counted.

Top module: `drift_compensator`

## Requirements
- R1: After synchronous reset, `ivl_countdown`, `adj_now`, `ivl_cfg` and `adj_cfg` are all zero and `sec_pulse` is low. The first second after reset is the first second of a one-second interval with zero adjustment.
- R2: Every second except the first of an interval lasts exactly `NOMINAL_TICKS` ticks. Only clock cycles with `tick_en` high count as ticks.
- R3: The first second of each interval lasts `NOMINAL_TICKS + adj` ticks. Here `adj` is the 8-bit two's-complement adjustment taken when the interval began: a positive value lengthens the second and a negative value shortens it. The range is -128 to +127.
- R4: An interval code `c` (8 bits, unsigned) gives an interval of `c+1` seconds. Code 0 makes every second the first of its interval, and code 255 gives 256 seconds.
- R5: During the first second of an interval, `ivl_countdown` equals the interval code. It drops by one at each second boundary. At the boundary of the second in which it is 0, it reloads from the pending code.
- R6: `adj_now` equals the adjustment in use during the first second of an interval. It is zero during every other second.
- R7: A write to either setting shows on `ivl_cfg`/`adj_cfg` in the next cycle. It leaves the running interval unchanged and takes effect only at the end of that interval. A later write before the interval ends replaces an earlier one. A write made in the same cycle as an interval's final tick applies to the next interval.
- R8: `sec_pulse` is high for exactly one clock cycle, in the cycle after the clock edge that consumed the last tick of a second. It is never high in two consecutive cycles.
- R9: The extreme settings behave as R3 and R4 state: an adjustment of +127 gives a first second of `NOMINAL_TICKS+127` ticks, -128 gives `NOMINAL_TICKS-128` ticks, and code 255 gives 256 seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One 32.768 kHz tick when high for a cycle |
| ivl_wr_en | input | 1 | Write strobe for the pending interval code |
| ivl_wr_code | input | 8 | Interval code (seconds minus one) |
| adj_wr_en | input | 1 | Write strobe for the pending adjustment |
| adj_wr_val | input | 8 | Signed tick adjustment |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |
| ivl_countdown | output | 8 | Seconds left in the current interval |
| adj_now | output | 8 | Adjustment applied to the current second |
| ivl_cfg | output | 8 | Pending interval code readback |
| adj_cfg | output | 8 | Pending adjustment readback |

## Verification
A reference model predicts the length, countdown and adjustment of every second. The bench compares each real second boundary against it across sparse and dense tick patterns.

The bench aims at the corner cases:
- Two writes within one interval, where a design that latched the first write or applied writes at once would misshape the current interval.
- A write landing exactly on an interval's final tick, which a design without the bypass would delay by a full interval.
- Adjustments of +127 and -128, where sign handling or width errors show up as wrong second lengths.
- A 256-second interval, where an 8-bit countdown that misses the wrap case would end the interval early or never reload.

// File: rtl/drift_comp_pkg.sv
package drift_comp_pkg;

    localparam int CODE_W = 8;
    localparam int ADJ_W  = 8;

    typedef logic [CODE_W-1:0]        ivl_code_t;
    typedef logic signed [ADJ_W-1:0]  adj_t;

    // settings as written by software
    typedef struct packed {
        ivl_code_t code;
        adj_t      adj;
    } comp_cfg_t;

    // state of the second now being counted
    typedef struct packed {
        ivl_code_t remain;   // seconds left after this one in the interval
        logic      first;    // this is the first second of the interval
        adj_t      adj;      // adjustment taken at interval start
    } sec_state_t;

    // ticks that make up the current second
    function automatic int second_ticks(input int nominal, input logic first, input adj_t adj);
        return first ? nominal + int'(adj) : nominal;
    endfunction

    function automatic logic interval_last(input ivl_code_t remain);
        return remain == '0;
    endfunction

endpackage

// File: rtl/drift_cfg_buffer.sv
module drift_cfg_buffer
    import drift_comp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      code_we,
    input  ivl_code_t code_wdata,
    input  logic      adj_we,
    input  adj_t      adj_wdata,
    output comp_cfg_t pend_q,
    output comp_cfg_t pend_next
);

    // pend_next also feeds the interval reload so a write on the final
    // tick is not lost
    always_comb begin
        pend_next = pend_q;
        if (code_we) pend_next.code = code_wdata;
        if (adj_we)  pend_next.adj  = adj_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_next;
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!code_we && !adj_we) |=> $stable(pend_q)) else $error("pending held"); // R7
    AST_PEND_CODE_TAKE: assert property (@(posedge clk) disable iff (rst)
        code_we |=> pend_q.code == $past(code_wdata)) else $error("code take"); // R7

endmodule

// File: rtl/drift_interval_seq.sv
module drift_interval_seq
    import drift_comp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       boundary,
    input  comp_cfg_t  pend_next,
    output sec_state_t st
);

    sec_state_t st_d;

    always_comb begin
        st_d = st;
        if (boundary) begin
            if (interval_last(st.remain)) begin
                st_d.remain = pend_next.code;
                st_d.first  = 1'b1;
                st_d.adj    = pend_next.adj;
            end else begin
                st_d.remain = st.remain - 1'b1;
                st_d.first  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.remain <= '0;
            st.first  <= 1'b1;
            st.adj    <= '0;
        end else begin
            st <= st_d;
        end
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(st)) else $error("state hold"); // R5
    AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (boundary && st.remain != '0) |=> (st.remain == $past(st.remain) - 8'd1) && !st.first)
        else $error("remain step"); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (boundary && st.remain == '0) |=> st.first && (st.adj == $past(pend_next.adj)))
        else $error("reload"); // R7

endmodule

// File: rtl/drift_tick_counter.sv
module drift_tick_counter
    import drift_comp_pkg::*;
#(
    parameter int NOMINAL_TICKS = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic first,
    input  adj_t adj,
    output logic boundary,
    output logic sec_pulse
);

    localparam int ADJ_MAX   = (2 ** (ADJ_W - 1)) - 1;
    localparam int MAX_TICKS = NOMINAL_TICKS + ADJ_MAX;
    localparam int CNT_W     = $clog2(MAX_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        last_idx = CNT_W'(second_ticks(NOMINAL_TICKS, first, adj) - 1);
        boundary = tick_en && (cnt_q == last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            sec_pulse <= 1'b0;
        end else begin
            sec_pulse <= boundary;
            if (tick_en) cnt_q <= boundary ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_idx) else $error("count range"); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> !sec_pulse) else $error("pulse width"); // R8
    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> $past(tick_en)) else $error("pulse without tick"); // R8

endmodule

// File: rtl/drift_compensator.sv
module drift_compensator
    import drift_comp_pkg::*;
#(
    parameter int NOMINAL_TICKS = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       ivl_wr_en,
    input  logic [7:0] ivl_wr_code,
    input  logic       adj_wr_en,
    input  logic [7:0] adj_wr_val,
    output logic       sec_pulse,
    output logic [7:0] ivl_countdown,
    output logic [7:0] adj_now,
    output logic [7:0] ivl_cfg,
    output logic [7:0] adj_cfg
);

    comp_cfg_t  pend_q;
    comp_cfg_t  pend_next;
    sec_state_t st;
    logic       boundary;

    drift_cfg_buffer u_cfg (
        .clk        (clk),
        .rst        (rst),
        .code_we    (ivl_wr_en),
        .code_wdata (ivl_code_t'(ivl_wr_code)),
        .adj_we     (adj_wr_en),
        .adj_wdata  (adj_t'(adj_wr_val)),
        .pend_q     (pend_q),
        .pend_next  (pend_next)
    );

    drift_interval_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .pend_next (pend_next),
        .st        (st)
    );

    drift_tick_counter #(.NOMINAL_TICKS(NOMINAL_TICKS)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .first     (st.first),
        .adj       (st.adj),
        .boundary  (boundary),
        .sec_pulse (sec_pulse)
    );

    always_comb begin
        ivl_countdown = st.remain;
        adj_now       = st.first ? st.adj : '0;
        ivl_cfg       = pend_q.code;
        adj_cfg       = pend_q.adj;
    end

    AST_NOW_STABLE: assert property (@(posedge clk) disable iff (rst)
        !sec_pulse |-> $stable(adj_now)) else $error("adj_now moved mid-second"); // R6

endmodule

// File: tb/drift_compensator_tb_top.sv
module drift_compensator_tb_top;

    localparam int NOM = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       ivl_wr_en = 1'b0;
    logic [7:0] ivl_wr_code = '0;
    logic       adj_wr_en = 1'b0;
    logic [7:0] adj_wr_val = '0;
    logic       sec_pulse;
    logic [7:0] ivl_countdown, adj_now, ivl_cfg, adj_cfg;

    always #10 clk = ~clk;

    drift_compensator #(.NOMINAL_TICKS(NOM)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .ivl_wr_en(ivl_wr_en), .ivl_wr_code(ivl_wr_code),
        .adj_wr_en(adj_wr_en), .adj_wr_val(adj_wr_val),
        .sec_pulse(sec_pulse), .ivl_countdown(ivl_countdown), .adj_now(adj_now),
        .ivl_cfg(ivl_cfg), .adj_cfg(adj_cfg)
    );

    typedef struct { int len; int cd; int adj; bit first; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int nticks = 0;
    int cyc = 0;
    int tick_mode = 0;
    bit tick_gate = 0;
    bit mon_on = 0;
    bit prev_pulse = 0;
    bit done = 0;
    int m_cd = 0, m_act = 0, m_pcode = 0, m_padj = 0;
    bit m_first = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int sx8(input logic [7:0] v);
        return int'($signed(v));
    endfunction

    function automatic void model_push();
        exp_t e;
        e.first = m_first;
        e.len   = m_first ? NOM + m_act : NOM;
        e.cd    = m_cd;
        e.adj   = m_first ? m_act : 0;
        exp_q.push_back(e);
    endfunction

    function automatic void model_advance();
        if (m_cd == 0) begin
            m_cd = m_pcode; m_act = m_padj; m_first = 1;
        end else begin
            m_cd = m_cd - 1; m_first = 0;
        end
        model_push();
    endfunction

    // tick source
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            tick_en = tick_gate && (tick_mode == 0 || (cyc % 3) == 0);
        end
    end

    // monitor: pops the expected second at each boundary and compares
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (sec_pulse) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(nticks == e.len, e.first ? "R3 first-second length" : "R2 plain second length",
                    nticks, e.len);
                chk(!prev_pulse, "R8 pulse one cycle", 1, 0);
                model_advance();
                nticks = 0;
            end
            if (sec_pulse || nticks == 20) begin
                chk(int'(ivl_countdown) == exp_q[0].cd, "R5 countdown", int'(ivl_countdown), exp_q[0].cd);
                chk(sx8(adj_now) == exp_q[0].adj, "R6 adj_now", sx8(adj_now), exp_q[0].adj);
            end
            if (tick_en) nticks++;
            prev_pulse = sec_pulse;
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!sec_pulse);
    endtask

    task automatic run_seconds(input int n);
        for (int i = 0; i < n; i++) wait_pulse();
    endtask

    // driver: write settings mid-second and update the model's pending copy
    task automatic set_cfg(input bit wc, input int code, input bit wa, input int adj);
        wait_pulse();
        repeat (10) @(posedge clk);
        #1;
        ivl_wr_en = wc; ivl_wr_code = code[7:0];
        adj_wr_en = wa; adj_wr_val = adj[7:0];
        if (wc) m_pcode = code;
        if (wa) m_padj = adj;
        @(posedge clk); #1;
        ivl_wr_en = 0; adj_wr_en = 0;
        @(negedge clk);
        chk(int'(ivl_cfg) == m_pcode, "R7 pending code readback", int'(ivl_cfg), m_pcode);
        chk(sx8(adj_cfg) == m_padj, "R7 pending adj readback", sx8(adj_cfg), m_padj);
    endtask

    task automatic poke_adj(input int adj);
        @(posedge clk); #1;
        adj_wr_en = 1; adj_wr_val = adj[7:0]; m_padj = adj;
        @(posedge clk); #1;
        adj_wr_en = 0;
    endtask

    // write timed to land on the final tick of an interval (code 0 active)
    task automatic write_on_edge(input int adj);
        wait_pulse();
        forever begin
            @(posedge clk); #1;
            if (nticks == exp_q[0].len - 1) break;
        end
        adj_wr_en = 1; adj_wr_val = adj[7:0]; m_padj = adj;
        @(posedge clk); #1;
        adj_wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sec_pulse == 0, "R1 pulse low in reset", int'(sec_pulse), 0);
        chk(ivl_countdown == 0, "R1 countdown zero", int'(ivl_countdown), 0);
        chk(adj_now == 0, "R1 adj_now zero", int'(adj_now), 0);
        chk(ivl_cfg == 0, "R1 code readback zero", int'(ivl_cfg), 0);
        chk(adj_cfg == 0, "R1 adj readback zero", int'(adj_cfg), 0);
        model_push();
        @(posedge clk); #1;
        rst = 0; tick_gate = 1; mon_on = 1;

        run_seconds(3);                       // R2 R4: code 0, no adjustment
        set_cfg(1, 2, 1, 5);                  // R3 R4 R7: 3-second interval, +5
        run_seconds(8);
        set_cfg(0, 0, 1, -7);                 // R7: adj only
        set_cfg(1, 3, 0, 0);                  // R4: 4-second interval
        run_seconds(10);
        set_cfg(1, 1, 1, 20);                 // R7: later write replaces earlier
        poke_adj(-30);
        run_seconds(6);
        tick_mode = 1;                        // R2: sparse ticks
        set_cfg(1, 0, 1, 127);                // R9: +127
        run_seconds(4);
        set_cfg(0, 0, 1, -128);               // R9: -128
        run_seconds(4);
        tick_mode = 0;
        set_cfg(0, 0, 1, 0);
        run_seconds(2);
        write_on_edge(33);                    // R7: write on final tick applies next
        run_seconds(3);
        set_cfg(1, 255, 1, 9);                // R9: 256-second interval
        set_cfg(1, 0, 1, 0);
        run_seconds(258);
        chk(exp_q.size() == 1, "R5 model queue depth", exp_q.size(), 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule